// File: doc/BRIEF.md
# Packed string compare index unit

The unit treats two 128-bit operands as sixteen unsigned byte lanes each, with lane 0 in the least significant byte. Each operand is read as a string that ends at its first zero byte. The unit compares the two strings lane against lane, treats lanes beyond both terminators as matching, and then inverts the outcome only inside the first string's live lanes. The result is a 16-bit mask that marks the lanes where the strings differ within the first string, plus every lane past both ends.

From that mask the unit reports the position of the lowest marked lane as a 5-bit index, or 16 when no lane is marked. It also reports a set of condition flags. A typical use is a length or first-difference scan. The caller reads the index to locate the first mismatch or terminator in a pair of 16-byte chunks, and reads the zero and sign flags to learn whether either chunk held the end of its string.

With the register option on (the default), every output is captured one clock after an input strobe and held until the next strobe. With the option off, the unit is purely combinational.

Top module: `psc_index_unit`

## Requirements
- R1: A lane of an operand is live when it and every lower lane hold a non-zero byte. An operand with no zero byte has all 16 lanes live.
- R2: The raw per-lane result is 1 when both lanes are live and their bytes are equal, or when neither lane is live. It is 0 otherwise.
- R3: `res_mask` equals the raw result XOR the live-lane mask of operand A. It therefore flips only the lanes that are live in A.
- R4: `res_index` is the position of the lowest set bit of `res_mask`, and is 16 when `res_mask` is zero.
- R5: `flag_c` is 1 exactly when `res_mask` is non-zero.
- R6: `flag_z` is 1 when operand A holds any zero byte. `flag_s` is 1 when operand B holds any zero byte.
- R7: `flag_o` equals bit 0 of `res_mask`. `flag_p` and `flag_a` are always 0.
- R8: With the register option on, results and `out_valid` = 1 appear in the cycle after `in_valid` is sampled high, and `out_valid` is 0 after a cycle with `in_valid` low. A synchronous active-high reset drives every output to 0.
- R9: With the register option on, the index, mask and flags keep their values through cycles with `in_valid` low, whatever the operands do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| op_a | input | 128 | First string operand, lane 0 in bits 7:0 |
| op_b | input | 128 | Second string operand, lane 0 in bits 7:0 |
| out_valid | output | 1 | Result valid |
| res_index | output | 5 | Lowest set lane of the result mask, 16 if none |
| res_mask | output | 16 | Polarity-adjusted per-lane result |
| flag_c | output | 1 | Result mask non-zero |
| flag_z | output | 1 | Operand A contains a zero byte |
| flag_s | output | 1 | Operand B contains a zero byte |
| flag_o | output | 1 | Bit 0 of the result mask |
| flag_p | output | 1 | Constant 0 |
| flag_a | output | 1 | Constant 0 |

## Verification
Several rules hold between the outputs on every cycle, and the assertions check them continuously. The index must name the lowest set bit of the mask and must never exceed 16. The carry flag must agree with whether the index is 16. The overflow flag must agree with whether the index is 0. The parity and auxiliary flags must stay at 0. The strobe-to-valid latency and the hold of results between strobes are also checked on every cycle. Whether the mask itself is right for the given operands cannot be seen from the outputs alone: terminator detection, the forcing of lanes past both ends, the inversion over A's live lanes, and the zero and sign flags are shown only by the bench. The bench scenarios cover identical strings, a lane 0 mismatch, a null in lane 0, operands with no nulls, staggered nulls, and random vectors with injected zero bytes.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int BYTE_W = 8;

  function automatic int idx_width(input int lanes);
    return $clog2(lanes + 1);
  endfunction
endpackage

// File: rtl/psc_lane_cmp.sv
module psc_lane_cmp #(
  parameter int LANES  = 16,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] a,
  input  logic [LANES*LANE_W-1:0] b,
  output logic [LANES-1:0]        eq,
  output logic [LANES-1:0]        nul_a,
  output logic [LANES-1:0]        nul_b
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    assign la       = a[i*LANE_W +: LANE_W];
    assign lb       = b[i*LANE_W +: LANE_W];
    assign eq[i]    = (la == lb);
    assign nul_a[i] = (la == '0);
    assign nul_b[i] = (lb == '0);
  end
endmodule

// File: rtl/psc_live_mask.sv
module psc_live_mask #(
  parameter int LANES = 16
) (
  input  logic [LANES-1:0] nul,
  output logic [LANES-1:0] live
);
  assign live[0] = ~nul[0];
  for (genvar i = 1; i < LANES; i++) begin : g_chain
    assign live[i] = live[i-1] & ~nul[i];
  end
endmodule

// File: rtl/psc_lsb_index.sv
module psc_lsb_index #(
  parameter int LANES = 16,
  parameter int IDX_W = 5
) (
  input  logic [LANES-1:0] vec,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = IDX_W'(LANES);
    for (int i = LANES - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/psc_index_unit.sv
module psc_index_unit
  import psc_pkg::*;
#(
  parameter int LANES   = 16,
  parameter int LANE_W  = BYTE_W,
  parameter bit REG_OUT = 1'b1,
  localparam int IDX_W  = idx_width(LANES),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              out_valid,
  output logic [IDX_W-1:0]  res_index,
  output logic [LANES-1:0]  res_mask,
  output logic              flag_c,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_o,
  output logic              flag_p,
  output logic              flag_a
);
  logic [LANES-1:0] eq, nul_a, nul_b, live_a, live_b, raw, pol;
  logic [IDX_W-1:0] idx_c;
  logic             c_c, z_c, s_c, o_c;

  psc_lane_cmp #(.LANES(LANES), .LANE_W(LANE_W)) u_cmp (
    .a(op_a), .b(op_b), .eq(eq), .nul_a(nul_a), .nul_b(nul_b)
  );

  psc_live_mask #(.LANES(LANES)) u_live_a (.nul(nul_a), .live(live_a));
  psc_live_mask #(.LANES(LANES)) u_live_b (.nul(nul_b), .live(live_b));

  assign raw = (eq & live_a & live_b) | ~(live_a | live_b);
  assign pol = raw ^ live_a;

  psc_lsb_index #(.LANES(LANES), .IDX_W(IDX_W)) u_idx (.vec(pol), .idx(idx_c));

  assign c_c = |pol;
  assign z_c = |nul_a;
  assign s_c = |nul_b;
  assign o_c = pol[0];

  assign flag_p = 1'b0;
  assign flag_a = 1'b0;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        res_index <= '0;
        res_mask  <= '0;
        flag_c    <= 1'b0;
        flag_z    <= 1'b0;
        flag_s    <= 1'b0;
        flag_o    <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          res_index <= idx_c;
          res_mask  <= pol;
          flag_c    <= c_c;
          flag_z    <= z_c;
          flag_s    <= s_c;
          flag_o    <= o_c;
        end
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign res_index = idx_c;
    assign res_mask  = pol;
    assign flag_c    = c_c;
    assign flag_z    = z_c;
    assign flag_s    = s_c;
    assign flag_o    = o_c;
  end
endmodule

// File: rtl/psc_index_unit_chk.sv
module psc_index_unit_chk #(
  parameter int LANES   = 16,
  parameter int IDX_W   = 5,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [IDX_W-1:0] res_index,
  input logic [LANES-1:0] res_mask,
  input logic             flag_c,
  input logic             flag_o,
  input logic             flag_p,
  input logic             flag_a
);
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(res_index) <= LANES)); // R4

  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (rst)
    (out_valid && int'(res_index) < LANES) |->
      (((32'(res_mask) >> res_index) & 32'd1) == 32'd1 &&
       (32'(res_mask) & ((32'd1 << res_index) - 32'd1)) == 32'd0)); // R4

  AST_IDX_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && int'(res_index) == LANES) |-> (res_mask == '0)); // R4

  AST_CARRY_IDX: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flag_c == (int'(res_index) != LANES))); // R5

  AST_OVF_IDX: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flag_o == (res_index == '0))); // R7

  AST_RSV_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !flag_p && !flag_a); // R7

  if (REG_OUT) begin : g_seq
    AST_LAT_ON: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R8
    AST_LAT_OFF: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R8
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(res_index) && $stable(res_mask) &&
                     $stable(flag_c) && $stable(flag_o))); // R9
  end
endmodule

bind psc_index_unit psc_index_unit_chk #(
  .LANES(LANES), .IDX_W(IDX_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .res_index(res_index), .res_mask(res_mask), .flag_c(flag_c),
  .flag_o(flag_o), .flag_p(flag_p), .flag_a(flag_a)
);

// File: tb/psc_index_unit_tb.sv
module psc_index_unit_tb;
  localparam int LANES = 16;
  localparam int DW    = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] op_a = '0, op_b = '0;
  logic          out_valid;
  logic [4:0]    res_index;
  logic [15:0]   res_mask;
  logic          flag_c, flag_z, flag_s, flag_o, flag_p, flag_a;

  int n_chk = 0;
  int n_bad = 0;
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  psc_index_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .res_index(res_index), .res_mask(res_mask),
    .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o),
    .flag_p(flag_p), .flag_a(flag_a)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ref_model(input logic [DW-1:0] a, input logic [DW-1:0] b,
                           output logic [15:0] m, output logic [4:0] idx,
                           output logic c, output logic z, output logic s,
                           output logic o);
    logic la, lb, ea, eb;
    ea = 1'b0; eb = 1'b0; z = 1'b0; s = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (a[8*i +: 8] == 8'h00) begin ea = 1'b1; z = 1'b1; end
      if (b[8*i +: 8] == 8'h00) begin eb = 1'b1; s = 1'b1; end
      la = !ea;
      lb = !eb;
      if (la && lb)        m[i] = (a[8*i +: 8] == b[8*i +: 8]);
      else if (!la && !lb) m[i] = 1'b1;
      else                 m[i] = 1'b0;
      if (la) m[i] = !m[i];
    end
    idx = 5'd16;
    for (int i = LANES - 1; i >= 0; i--) if (m[i]) idx = 5'(i);
    c = (m != 16'h0);
    o = m[0];
  endtask

  task automatic apply(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [15:0] em; logic [4:0] ei; logic ec, ez, es, eo;
    ref_model(a, b, em, ei, ec, ez, es, eo);
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 out_valid after strobe", 32'(out_valid), 32'd1);
    chk("R1 R2 R3 res_mask", 32'(res_mask), 32'(em));
    chk("R4 res_index", 32'(res_index), 32'(ei));
    chk("R5 flag_c", 32'(flag_c), 32'(ec));
    chk("R6 flag_z", 32'(flag_z), 32'(ez));
    chk("R6 flag_s", 32'(flag_s), 32'(es));
    chk("R7 flag_o", 32'(flag_o), 32'(eo));
    chk("R7 flag_p flag_a", {30'd0, flag_p, flag_a}, 32'd0);
    op_a = ~a; op_b = {b[63:0], b[127:64]};
    @(negedge clk);
    chk("R8 out_valid idle", 32'(out_valid), 32'd0);
    chk("R9 hold mask", 32'(res_mask), 32'(em));
    chk("R9 hold index", 32'(res_index), 32'(ei));
  endtask

  function automatic logic [DW-1:0] rnd_str(input int zero_odds);
    logic [DW-1:0] v;
    for (int i = 0; i < LANES; i++) begin
      v[8*i +: 8] = 8'($urandom_range(255, 1));
      if (zero_odds > 0 && $urandom_range(zero_odds - 1, 0) == 0) v[8*i +: 8] = 8'h00;
    end
    return v;
  endfunction

  function automatic logic [DW-1:0] with_nul(input logic [DW-1:0] v, input int lane);
    logic [DW-1:0] r;
    r = v;
    r[8*lane +: 8] = 8'h00;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] s1, s2;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R8 reset out_valid", 32'(out_valid), 32'd0);
    chk("R8 reset res_mask", 32'(res_mask), 32'd0);
    chk("R8 reset res_index", 32'(res_index), 32'd0);
    chk("R8 reset flags", {26'd0, flag_c, flag_z, flag_s, flag_o, flag_p, flag_a}, 32'd0);
    rst = 1'b0;

    s1 = with_nul(rnd_str(0), 5);
    apply(s1, s1);                                   // identical strings
    s2 = s1; s2[7:0] = s1[7:0] ^ 8'h01;
    apply(s1, s2);                                   // mismatch lane 0
    apply(with_nul(s1, 0), s1);                      // null lane 0 in A
    apply(s1, with_nul(s1, 0));                      // null lane 0 in B
    apply(with_nul(s1, 0), with_nul(s2, 0));         // both empty
    s1 = rnd_str(0);
    apply(s1, s1);                                   // no nulls, equal
    s2 = s1; s2[8*15 +: 8] = s1[8*15 +: 8] ^ 8'h80;
    apply(s1, s2);                                   // no nulls, differ lane 15
    apply(with_nul(s1, 3), with_nul(s1, 9));         // A shorter
    apply(with_nul(s1, 11), with_nul(s1, 2));        // B shorter

    for (int k = 0; k < 400; k++) begin
      s1 = rnd_str(8);
      s2 = rnd_str(8);
      for (int i = 0; i < LANES; i++)
        if ($urandom_range(1, 0) == 0) s2[8*i +: 8] = s1[8*i +: 8];
      apply(s1, s2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule